// File: doc/BRIEF.md
# Collision-Vector Pipeline Admission Controller

This block sits at the entry of a nonlinear pipeline, one whose stages are reused through feedback paths. Every clock it decides whether a new data item may enter without meeting an older item at a shared stage. It keeps a status register that shifts right by one position each clock, so each bit moves one slot closer to the present. Each accepted item ORs a fixed collision vector, derived from the pipeline's reservation pattern, into that register. Bit 0 of the status register says whether the current slot is free.

A permitted slot does not have to be used. In greedy mode every permitted slot that has a pending request is taken. In skip mode a mask declines chosen opportunities inside a repeating window, which lets a different sustained throughput be selected. Software loads the mask through a small write port. Two saturating counters record accepted items and elapsed slots since the last clear, so throughput can be measured as the ratio of the two.

Top module: `cv_admit`

## Requirements
- R1: After reset the status register is all zeros: `load_ok` is 1, both counters are 0, the skip mask is 0 and the opportunity index is 0.
- R2: On a clock with an accepted item, the status register becomes its right-shifted value ORed with the collision vector. On any other clock it becomes the right-shifted value alone, with a 0 entering at the top bit.
- R3: `load_ok` is the inverse of status bit 0. `load_acc` is high only in a cycle where both `req` and `load_ok` are high. A request held while `load_ok` is low is accepted in the first cycle in which `load_ok` returns to 1.
- R4: With `pol_sel`=0 (greedy), every cycle with `req` and `load_ok` both high is accepted. With the default vector 00010110 (bit 7 down to bit 0) and a constant request from reset, accepts fall on relative slots 0, 1, 7, 8, 14, 15, which is 2 per 7.
- R5: An opportunity is a cycle with `req` and `load_ok` both high. Each opportunity advances the opportunity index by one, wrapping from MW-1 to 0. With `pol_sel`=1, an opportunity whose index selects a 1 in the skip mask is declined, and the status register then only shifts.
- R6: When `mask_we` is 1, the mask is loaded from `mask_wd` and the opportunity index returns to 0. This takes priority over advancing the index.
- R7: `slot_cnt` increases by one every clock. `acc_cnt` increases by one on every accepted item. A clock with `clr` high sets both counters to 0, and that clock is not counted.
- R8: Each counter holds at 2^CW-1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one pipeline slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | A data item is waiting to enter |
| pol_sel | input | 1 | 0 = greedy, 1 = skip mask applied |
| mask_we | input | 1 | Write strobe for the skip mask |
| mask_wd | input | MW | New skip mask; bit i declines opportunity i |
| clr | input | 1 | Clears both counters |
| load_ok | output | 1 | The current slot is free of collisions |
| load_acc | output | 1 | The item is accepted this cycle |
| acc_cnt | output | CW | Accepted items since the last clear |
| slot_cnt | output | CW | Slots since the last clear |

## Verification
`load_ok` and `load_acc` are combinational from the status register, the mask and the present inputs. They are therefore due in the same cycle as the stimulus, based on the state left by the previous edge. The bench drives inputs on the falling edge and samples a quarter period later, before the next rising edge. The counters and the mask take one rising edge to change. Counter checks are made after the last counted edge, and the sequences of `load_ok` and `load_acc` expose the register's shifting and ORing edge by edge.

// File: rtl/cv_admit.sv
module cv_admit #(
  parameter int W = 8,
  parameter logic [W-1:0] CVEC = 8'b00010110,
  parameter int MW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          pol_sel,
  input  logic          mask_we,
  input  logic [MW-1:0] mask_wd,
  input  logic          clr,
  output logic          load_ok,
  output logic          load_acc,
  output logic [CW-1:0] acc_cnt,
  output logic [CW-1:0] slot_cnt
);
  localparam int IW = (MW > 1) ? $clog2(MW) : 1;
  localparam logic [IW-1:0] LAST = IW'(MW - 1);
  localparam logic [CW-1:0] TOP = '1;

  logic [W-1:0]  stat;
  logic [MW-1:0] mask;
  logic [IW-1:0] idx;
  logic          opp;

  assign load_ok  = ~stat[0];
  assign opp      = req & load_ok;
  assign load_acc = opp & ~(pol_sel & mask[idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= load_acc ? ((stat >> 1) | CVEC) : (stat >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      idx  <= '0;
    end else if (mask_we) begin
      mask <= mask_wd;
      idx  <= '0;
    end else if (opp) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc_cnt  <= '0;
      slot_cnt <= '0;
    end else begin
      if (slot_cnt != TOP) slot_cnt <= slot_cnt + 1'b1;
      if (load_acc && acc_cnt != TOP) acc_cnt <= acc_cnt + 1'b1;
    end
  end

  // R2
  vec_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_acc |=> ((stat & CVEC) == CVEC));
  // R2
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_acc |=> (stat[W-1] == 1'b0));
  // R3
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ok |-> !load_acc);
  // R4
  greedy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pol_sel && req && load_ok) |-> load_acc);
  // R6
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(mask_wd) && idx == '0));
  // R7
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && slot_cnt != TOP) |=> slot_cnt == $past(slot_cnt) + 1'b1);
  // R8
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && acc_cnt == TOP) |=> acc_cnt == TOP);
endmodule

// File: tb/test_cv_admit.sv
module test_cv_admit;
  logic clk = 0, rst_n = 0, req = 0, pol_sel = 0, mask_we = 0, clr = 0;
  logic [7:0] mask_wd = '0;
  logic load_ok, load_acc;
  logic [15:0] acc_cnt, slot_cnt;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  cv_admit i_cv_admit (.clk, .rst_n, .req, .pol_sel, .mask_we, .mask_wd, .clr,
    .load_ok, .load_acc, .acc_cnt, .slot_cnt);

  // {load_ok, load_acc} per slot with req held high in greedy mode
  localparam logic [1:0] GREEDY_TBL [16] = '{2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; req = 0; pol_sel = 0; mask_we = 0; clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(input logic r, input logic expok, input logic expacc, input string tag);
    @(negedge clk); req = r; #5;
    check({tag, " ok"}, load_ok, expok);
    check({tag, " acc"}, load_acc, expacc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #5;
    check("R1 load_ok", load_ok, 1);
    check("R1 acc_cnt", acc_cnt, 0);
    check("R1 slot_cnt", slot_cnt, 0);

    // R4 R2 greedy table
    @(negedge clk); clr = 1;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); clr = 0; req = 1; #5;
      check($sformatf("R4 greedy ok k=%0d", k), load_ok, GREEDY_TBL[k][1]);
      check($sformatf("R2 greedy acc k=%0d", k), load_acc, GREEDY_TBL[k][0]);
    end
    @(negedge clk); req = 0; #5;
    check("R7 acc_cnt", acc_cnt, 6);
    check("R7 slot_cnt", slot_cnt, 16);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; #5;
    check("R7 clr acc", acc_cnt, 0);
    check("R7 clr slot", slot_cnt, 0);

    // R3 held request
    do_reset();
    step(1, 1, 1, "R3 k0");
    step(0, 1, 0, "R3 k1");
    step(1, 0, 0, "R3 held k2");
    step(1, 0, 0, "R3 held k3");
    step(1, 1, 1, "R3 held k4");

    // R5 skip mask declines second opportunity
    do_reset();
    @(negedge clk); mask_we = 1; mask_wd = 8'b00000010; pol_sel = 1;
    @(negedge clk); mask_we = 0;
    step(1, 1, 1, "R5 k0");
    step(1, 1, 0, "R5 skip k1");
    step(1, 0, 0, "R5 k2");
    step(1, 0, 0, "R5 k3");
    step(1, 1, 1, "R5 k4");
    step(1, 0, 0, "R5 k5");
    step(1, 0, 0, "R5 k6");
    step(1, 0, 0, "R5 k7");
    step(1, 1, 1, "R5 k8");

    // R6 mask write resets index
    do_reset();
    @(negedge clk); mask_we = 1; mask_wd = 8'hFF; pol_sel = 1;
    @(negedge clk); mask_we = 0;
    step(1, 1, 0, "R6 all-skip a");
    step(1, 1, 0, "R6 all-skip b");
    step(1, 1, 0, "R6 all-skip c");
    @(negedge clk); req = 0; mask_we = 1; mask_wd = 8'b00000001;
    @(negedge clk); mask_we = 0;
    step(1, 1, 0, "R6 idx0 declined");
    step(1, 1, 1, "R6 idx1 taken");

    // R8 slot counter saturation
    do_reset();
    @(negedge clk); req = 0; clr = 1;
    @(negedge clk); clr = 0;
    repeat (65540) @(negedge clk);
    #5;
    check("R8 slot_cnt saturates", slot_cnt, 16'hFFFF);
    @(negedge clk); #5;
    check("R8 slot_cnt holds", slot_cnt, 16'hFFFF);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; #5;
    check("R7 clr after sat", slot_cnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule